// File: doc/BRIEF.md
# Frequency Watchdog with Safe-Code Fallback

This block supervises a programmable clock-frequency setting. When enabled, it measures a timeout that is a small multiple of a selectable base period. The host restarts the full timeout with any register access, which it signals through a one-cycle service strobe. If the host stays silent until the timeout runs out, the block enters an alarm state. In that state it replaces the live 5-bit frequency-select code with a stored fallback code, raises a readable alarm flag, and emits a single-cycle reset request toward the rest of the system.

The base period comes from a free-running prescaler on the reference clock. One unit lasts `UNIT_DIV` reference cycles, about 290 ms at the default. The short base is one unit. The long base is `LONG_RATIO` units, which makes 1160 ms at the default ratio of 4. The alarm stays latched while the watchdog remains enabled. Clearing the enable is the only way back to normal operation.

Top module: `wdt_safe_freq`

## Requirements
- R1: Out of reset, `alarm` and `rst_req` are 0 and `freq_code` equals `norm_code`.
- R2: The timeout is L = `mult` × B units of `UNIT_DIV` cycles. B is 1 when `base_sel` is 0 and `LONG_RATIO` when it is 1. Timing starts at the clock edge that first samples `wd_en` high, and `alarm` reads 1 exactly L×`UNIT_DIV` cycles after that edge, not one cycle sooner.
- R3: A `mult` of 0 counts as 8.
- R4: A `service` pulse sampled while armed restarts the full timeout, prescaler included, from the edge that sampled it.
- R5: While `alarm` is 1, `freq_code` follows `safe_code`. Otherwise it follows `norm_code`. Both paths are combinational.
- R6: `rst_req` is high for exactly one cycle, in the same cycle that `alarm` first reads 1. There is exactly one pulse per timeout.
- R7: While enabled, the alarm is sticky. `service` pulses in the alarm state have no effect.
- R8: With `wd_en` low at an edge, `alarm` reads 0 after that edge and `freq_code` returns to `norm_code`. A later enable starts a fresh timeout.
- R9: While `wd_en` is 0, no alarm and no reset request occur, however long the wait.
- R10: `mult` and `base_sel` are sampled only when the timeout is loaded. Changes mid-count do not alter the running timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_en | input | 1 | Watchdog enable |
| base_sel | input | 1 | 0 selects the short base period, 1 selects the long one |
| mult | input | MULT_W | Timeout multiple (0 means 8) |
| safe_code | input | CODE_W | Fallback frequency code used in alarm |
| norm_code | input | CODE_W | Live frequency code |
| service | input | 1 | Host access strobe that restarts the timeout |
| freq_code | output | CODE_W | Effective frequency code |
| alarm | output | 1 | Alarm status, 1 while in alarm |
| rst_req | output | 1 | One-cycle reset request on alarm entry |

## Verification
The properties take for granted that reset is held low through the first edges, so the alarm flag starts cleared. They also assume `wd_en` carries a known level at every edge, because the sticky-alarm and clear-on-disable rules are keyed to it. The stimulus keeps within these bounds: it changes inputs only on falling edges, holds reset for three cycles at the start, and never leaves the enable undriven. Expiry is spread over many distinct multiples and both bases. A short `UNIT_DIV` keeps every timeout within a few hundred cycles.

// File: rtl/wdt_safe_freq.sv
module wdt_safe_freq #(
  parameter int UNIT_DIV   = 4152220,
  parameter int LONG_RATIO = 4,
  parameter int CODE_W     = 5,
  parameter int MULT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_en,
  input  logic              base_sel,
  input  logic [MULT_W-1:0] mult,
  input  logic [CODE_W-1:0] safe_code,
  input  logic [CODE_W-1:0] norm_code,
  input  logic              service,
  output logic [CODE_W-1:0] freq_code,
  output logic              alarm,
  output logic              rst_req
);
  localparam int MAX_MULT = 1 << MULT_W;
  localparam int CW       = $clog2(MAX_MULT * LONG_RATIO + 1);
  localparam int PW       = $clog2(UNIT_DIV);

  logic [PW-1:0] presc;
  logic [CW-1:0] cnt;
  logic          en_q, alarm_q, pulse_q;

  wire           armed     = wd_en & ~alarm_q;
  wire           load      = armed & (service | ~en_q);
  wire           unit_tick = (presc == PW'(UNIT_DIV - 1));
  wire  [CW-1:0] mult_eff  = (mult == '0) ? CW'(MAX_MULT) : CW'(mult);
  wire  [CW-1:0] load_val  = base_sel ? CW'(mult_eff * LONG_RATIO) : mult_eff;
  wire           expire    = armed & ~load & unit_tick & (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      alarm_q <= 1'b0;
      pulse_q <= 1'b0;
      presc   <= '0;
      cnt     <= '0;
    end else begin
      en_q    <= wd_en;
      pulse_q <= expire;
      if (!wd_en)      alarm_q <= 1'b0;
      else if (expire) alarm_q <= 1'b1;
      if (!armed) begin
        presc <= '0;
        cnt   <= '0;
      end else if (load) begin
        presc <= '0;
        cnt   <= load_val;
      end else if (unit_tick) begin
        presc <= '0;
        cnt   <= cnt - 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  assign freq_code = alarm_q ? safe_code : norm_code;
  assign alarm     = alarm_q;
  assign rst_req   = pulse_q;
endmodule

module wdt_safe_freq_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_en,
  input logic alarm,
  input logic rst_req
);
  assert_pulse_in_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> alarm);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_entry_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> rst_req);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && wd_en) |=> alarm);
  assert_clear_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !alarm);
  assert_alarm_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(wd_en));
endmodule

bind wdt_safe_freq wdt_safe_freq_chk u_chk (.*);

// File: tb/tb_wdt_safe_freq.sv
`timescale 1ns/1ps
module tb_wdt_safe_freq;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst_n, wd_en, base_sel, service;
  logic [2:0] mult;
  logic [4:0] safe_code, norm_code, freq_code;
  logic       alarm, rst_req;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  wdt_safe_freq #(.UNIT_DIV(DIV), .LONG_RATIO(4), .CODE_W(5), .MULT_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .base_sel(base_sel), .mult(mult),
    .safe_code(safe_code), .norm_code(norm_code), .service(service),
    .freq_code(freq_code), .alarm(alarm), .rst_req(rst_req));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp_v, cyc);
    end
  endtask

  function automatic int ldv(input int m, input bit s);
    return ((m == 0) ? 8 : m) * (s ? 4 : 1);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input int m, input bit s);
    mult = m[2:0];
    base_sel = s;
    wd_en = 1'b1;
    exp_q.push_back(cyc + 1 + ldv(m, s) * DIV);
  endtask

  task automatic svc(input int len);
    void'(exp_q.pop_back());
    exp_q.push_back(cyc + 1 + len * DIV);
    service = 1'b1;
    step(1);
    service = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rst_req === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 actual=unexpected pulse expected=none (cycle %0d)", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk("R2", cyc, e);
        chk("R6", int'(alarm), 1);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wd_en = 1'b0; base_sel = 1'b0; service = 1'b0;
    mult = 3'd7; safe_code = 5'h1A; norm_code = 5'h05;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1", int'(alarm), 0);
    chk("R1", int'(rst_req), 0);
    chk("R1", int'(freq_code), 5'h05);

    step(300);
    chk("R9", int'(alarm), 0);
    chk("R9", exp_q.size(), 0);

    arm(3, 1'b0);
    step(15);
    chk("R2", int'(alarm), 0);
    step(1);
    chk("R2", int'(alarm), 1);
    chk("R5", int'(freq_code), 5'h1A);
    safe_code = 5'h0B;
    step(1);
    chk("R5", int'(freq_code), 5'h0B);
    chk("R6", int'(rst_req), 0);

    service = 1'b1;
    step(1);
    service = 1'b0;
    step(40);
    chk("R7", int'(alarm), 1);
    chk("R7", int'(freq_code), 5'h0B);

    wd_en = 1'b0;
    step(1);
    chk("R8", int'(alarm), 0);
    chk("R8", int'(freq_code), 5'h05);
    norm_code = 5'h13;
    step(1);
    chk("R5", int'(freq_code), 5'h13);

    arm(2, 1'b1);
    step(39);
    chk("R2", int'(alarm), 0);
    step(2);
    chk("R2", int'(alarm), 1);
    wd_en = 1'b0;
    step(2);

    arm(0, 1'b0);
    step(40);
    chk("R3", int'(alarm), 0);
    step(1);
    chk("R3", int'(alarm), 1);
    wd_en = 1'b0;
    step(2);

    arm(4, 1'b0);
    step(12);
    svc(4);
    step(8);
    chk("R4", int'(alarm), 0);
    step(11);
    chk("R4", int'(alarm), 0);
    step(1);
    chk("R4", int'(alarm), 1);
    wd_en = 1'b0;
    step(2);

    arm(2, 1'b0);
    step(3);
    mult = 3'd7;
    base_sel = 1'b1;
    step(7);
    chk("R10", int'(alarm), 0);
    step(1);
    chk("R10", int'(alarm), 1);
    wd_en = 1'b0;
    step(2);

    arm(7, 1'b1);
    step(140);
    chk("R8", int'(alarm), 0);
    step(1);
    chk("R8", int'(alarm), 1);
    wd_en = 1'b0;
    step(2);
    chk("R8", int'(alarm), 0);

    step(5);
    chk("R6", exp_q.size(), 0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule